// File: doc/BRIEF.md
# Bipolar Contrast Gain Control Stage

This block is the contrast-adapting stage that sits between a center-surround
filter and a spiking output layer in a pixel-streaming vision pipeline. It
receives one signed current sample per pixel in raster order. For each pixel it
keeps a bipolar voltage and advances it by one forward-Euler step per frame.
The step charges the voltage with the input current and discharges it through
a leak conductance. The updated voltage is streamed out with a fixed latency.

The leak is not a fixed constant. The block squares each pixel's fresh voltage,
scales the square and adds a floor. It passes the result through a per-pixel
first-order temporal low-pass filter and stores it. In the next frame it blurs
the stored value horizontally with a small binomial kernel to form that pixel's
conductance. Strong recent activity in a neighbourhood therefore raises the
leak there and pulls the response back down. The square gain, the floor and the
filter time constant set whether the response is transient or sustained. The
filtered values are held in two banks that swap at every frame boundary, so a
frame always uses conductances built entirely from the previous frame.

After reset a control state machine walks all pixel addresses and zeroes both
state memories (ST_CLEAR). It then waits for a frame's first pixel (ST_IDLE) and
counts pixels through the frame (ST_ACTIVE). The transitions are:
- CLEAR_DONE moves ST_CLEAR to ST_IDLE once the last address is cleared.
- FRAME_START moves ST_IDLE to ST_ACTIVE when a pixel is accepted.
- FRAME_END moves ST_ACTIVE back to ST_IDLE when the last pixel of the frame is accepted.
- Every other cycle holds the current state.

Top module: `bipolar_gain_ctrl`

## Requirements
- R1: While reset is high, and for the COLS*ROWS cycles after reset falls, o_valid is low and inputs are ignored. All pixel voltages and all filtered values then start at zero.
- R2: A pixel presented with i_valid high in cycle t, outside the clear window, gives exactly one o_valid pulse, carrying its new voltage, in cycle t+2, and in the same order as the inputs.
- R3: Pixels are counted only in cycles with i_valid high, in raster order, column index fastest. The count wraps after COLS*ROWS pixels, and idle cycles between pixels do not change which pixel comes next.
- R4: The new voltage is v + ((I - ((g*v) >>> FRAC)) >>> DT_SH), where v is the pixel's stored voltage, I is i_cur, g is its conductance, all shifts are arithmetic (floor), and voltages and currents are signed with FRAC fraction bits.
- R5: The conductance of pixel (r,c) is (qf[c-1] + 2*qf[c] + qf[c+1]) >> 2 over the previous frame's filtered values in row r. A missing neighbour at a row edge is replaced by qf[c]. The result is limited to at most G_MAX.
- R6: From each new voltage V the block forms q = G0 + ((((V*V) >> FRAC) * LAMBDA) >> FRAC), computed at full width and saturated to 2^Q_W - 1.
- R7: The stored filtered value of a pixel becomes qf + ((q - qf) >>> TAU_SH), where qf is the value read for that pixel at the start of its update.
- R8: The new voltage saturates to the signed DATA_W range, -2^(DATA_W-1) to 2^(DATA_W-1)-1.
- R9: Filtered values written during frame n affect only the conductances of frame n+1. The read bank changes only on acceptance of the last pixel of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | A pixel current is present this cycle |
| i_cur | input | DATA_W | Signed center-surround current, FRAC fraction bits |
| o_valid | output | 1 | An updated voltage is present this cycle |
| o_v | output | DATA_W | Signed updated bipolar voltage, FRAC fraction bits |

## Verification
The bound checker watches the cycle-level control on every cycle:
- the two-cycle latency in both directions between acceptance and output;
- the pixel counter stepping, wrapping and holding through idle cycles and the clear sweep;
- the read bank flipping only on a frame's last pixel;
- the conductance never exceeding its cap.

The arithmetic can only be shown by the scenarios, through a scoreboard fed by an independent per-pixel model. The scenarios cover:
- the exact Euler step;
- the blur at row edges;
- the quadratic term saturating under full-scale drive;
- the temporal filter over many frames;
- voltage saturation in both directions;
- frames broken by idle gaps;
- junk driven during the clear window.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

    // Control states of the frame sequencer
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } bgc_state_e;

endpackage

// File: rtl/bgc_sequencer.sv
module bgc_sequencer
    import bgc_pkg::*;
#(
    parameter int COLS = 8,
    parameter int ROWS = 8,
    localparam int NPIX  = COLS * ROWS,
    localparam int PIX_W = $clog2(NPIX),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             acc,
    output logic [PIX_W-1:0] pix,
    output logic [COL_W-1:0] col,
    output logic             bank,
    output logic             clr_en,
    output logic [PIX_W-1:0] clr_addr,
    output bgc_state_e       state
);

    bgc_state_e       state_q, state_d;
    logic [PIX_W-1:0] pix_q;
    logic [COL_W-1:0] col_q;
    logic [PIX_W-1:0] clr_q;
    logic             bank_q;
    logic             last_pix;
    logic             last_clr;

    assign last_pix = (pix_q == PIX_W'(NPIX - 1));
    assign last_clr = (clr_q == PIX_W'(NPIX - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        acc     = 1'b0;
        clr_en  = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                clr_en = 1'b1;
                if (last_clr) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                acc = in_valid;
                if (in_valid && !last_pix) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                acc = in_valid;
                if (in_valid && last_pix) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_CLEAR;
            end
        endcase
    end

    // Pixel, column, clear and bank counters
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            col_q  <= '0;
            clr_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            if (clr_en) begin
                clr_q <= last_clr ? '0 : clr_q + PIX_W'(1);
            end
            if (acc) begin
                if (last_pix) begin
                    pix_q  <= '0;
                    bank_q <= ~bank_q;
                end else begin
                    pix_q <= pix_q + PIX_W'(1);
                end
                if (col_q == COL_W'(COLS - 1)) begin
                    col_q <= '0;
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end
        end
    end

    assign pix      = pix_q;
    assign col      = col_q;
    assign bank     = bank_q;
    assign clr_addr = clr_q;
    assign state    = state_q;

endmodule

// File: rtl/bgc_leak.sv
module bgc_leak #(
    parameter int COLS   = 8,
    parameter int ROWS   = 8,
    parameter int DATA_W = 16,
    parameter int FRAC   = 8,
    parameter int Q_W    = 16,
    parameter int TAU_SH = 1,
    parameter int G0     = 16,
    parameter int LAMBDA = 256,
    parameter int LAM_W  = 16,
    parameter int G_MAX  = 192,
    localparam int NPIX  = COLS * ROWS,
    localparam int PIX_W = $clog2(NPIX),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     clr_en,
    input  logic [PIX_W-1:0]         clr_addr,
    input  logic [PIX_W-1:0]         rd_pix,
    input  logic [COL_W-1:0]         rd_col,
    input  logic                     rd_bank,
    output logic [Q_W-1:0]           g_out,
    output logic [Q_W-1:0]           q_mid,
    input  logic                     wr_en,
    input  logic [PIX_W-1:0]         wr_pix,
    input  logic                     wr_bank,
    input  logic signed [DATA_W-1:0] wr_v,
    input  logic [Q_W-1:0]           wr_qold
);

    localparam int SW = 2 * DATA_W;
    localparam int PW = SW + LAM_W;
    localparam int BW = Q_W + 2;
    localparam logic [LAM_W-1:0] LAM_V  = LAM_W'(LAMBDA);
    localparam logic [PW:0]      QMAX_E = (PW+1)'(2**Q_W - 1);

    // Read addresses with row-edge replication
    logic [PIX_W-1:0] addr_a, addr_c;
    assign addr_a = (rd_col == '0) ? rd_pix : rd_pix - PIX_W'(1);
    assign addr_c = (rd_col == COL_W'(COLS - 1)) ? rd_pix : rd_pix + PIX_W'(1);

    // Write port
    logic [PIX_W-1:0] waddr;
    logic [Q_W-1:0]   wdata;
    logic [Q_W-1:0]   qf_new;
    assign waddr = clr_en ? clr_addr : wr_pix;
    assign wdata = clr_en ? '0 : qf_new;

    logic [Q_W-1:0] rd_a [2];
    logic [Q_W-1:0] rd_b [2];
    logic [Q_W-1:0] rd_c [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [Q_W-1:0] mem [NPIX];
        logic           we;
        assign we = clr_en || (wr_en && (wr_bank == 1'(b)));
        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wdata;
            end
        end
        assign rd_a[b] = mem[addr_a];
        assign rd_b[b] = mem[rd_pix];
        assign rd_c[b] = mem[addr_c];
    end

    // Horizontal binomial blur and cap
    logic [Q_W-1:0] qa, qb, qc;
    logic [BW-1:0]  bsum, blur;
    assign qa   = rd_a[rd_bank];
    assign qb   = rd_b[rd_bank];
    assign qc   = rd_c[rd_bank];
    assign bsum = BW'(qa) + (BW'(qb) << 1) + BW'(qc);
    assign blur = bsum >> 2;
    assign g_out = (blur > BW'(G_MAX)) ? Q_W'(G_MAX) : Q_W'(blur);
    assign q_mid = qb;

    // Quadratic drive at full width, then rescaled and saturated
    logic signed [SW-1:0] sq;
    logic [SW-1:0]        vsq;
    logic [PW-1:0]        prod, scaled;
    logic [PW:0]          qsum;
    logic [Q_W-1:0]       q_sat;
    assign sq     = SW'(wr_v) * SW'(wr_v);
    assign vsq    = $unsigned(sq) >> FRAC;
    assign prod   = PW'(vsq) * PW'(LAM_V);
    assign scaled = prod >> FRAC;
    assign qsum   = (PW+1)'(scaled) + (PW+1)'(G0);
    assign q_sat  = (qsum > QMAX_E) ? {Q_W{1'b1}} : Q_W'(qsum);

    // First-order temporal low-pass
    logic signed [Q_W:0] qdiff, qtmp;
    assign qdiff  = $signed({1'b0, q_sat}) - $signed({1'b0, wr_qold});
    assign qtmp   = $signed({1'b0, wr_qold}) + (qdiff >>> TAU_SH);
    assign qf_new = Q_W'(qtmp);

endmodule

// File: rtl/bgc_euler.sv
module bgc_euler #(
    parameter int COLS   = 8,
    parameter int ROWS   = 8,
    parameter int DATA_W = 16,
    parameter int FRAC   = 8,
    parameter int Q_W    = 16,
    parameter int DT_SH  = 2,
    localparam int NPIX  = COLS * ROWS,
    localparam int PIX_W = $clog2(NPIX)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_en,
    input  logic [PIX_W-1:0]         clr_addr,
    input  logic                     acc,
    input  logic [PIX_W-1:0]         pix,
    input  logic signed [DATA_W-1:0] cur,
    input  logic [Q_W-1:0]           g_in,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_v,
    output logic [PIX_W-1:0]         out_pix
);

    localparam int GW = Q_W + DATA_W + 1;
    localparam int EW = GW + 1;
    localparam logic signed [EW-1:0] VMAX_E = EW'(2**(DATA_W-1) - 1);
    localparam logic signed [EW-1:0] VMIN_E = -VMAX_E - EW'(1);

    logic signed [DATA_W-1:0] vmem [NPIX];

    // Stage 1 registers
    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_cur;
    logic signed [DATA_W-1:0] s1_vold;
    logic [Q_W-1:0]           s1_g;
    logic [PIX_W-1:0]         s1_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= acc;
        end
        if (acc) begin
            s1_cur  <= cur;
            s1_vold <= vmem[pix];
            s1_g    <= g_in;
            s1_pix  <= pix;
        end
    end

    // Euler step with floor shifts and saturation
    logic signed [GW-1:0]     gv, leak;
    logic signed [EW-1:0]     diff, step, vsum;
    logic signed [DATA_W-1:0] v_new;

    assign gv   = GW'($signed({1'b0, s1_g})) * GW'(s1_vold);
    assign leak = gv >>> FRAC;
    assign diff = EW'(s1_cur) - EW'(leak);
    assign step = diff >>> DT_SH;
    assign vsum = EW'(s1_vold) + step;

    always_comb begin
        if (vsum > VMAX_E) begin
            v_new = DATA_W'(VMAX_E);
        end else if (vsum < VMIN_E) begin
            v_new = DATA_W'(VMIN_E);
        end else begin
            v_new = DATA_W'(vsum);
        end
    end

    // Voltage memory write
    always_ff @(posedge clk) begin
        if (clr_en) begin
            vmem[clr_addr] <= '0;
        end else if (s1_valid) begin
            vmem[s1_pix] <= v_new;
        end
    end

    // Stage 2 / output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
        out_v   <= v_new;
        out_pix <= s1_pix;
    end

endmodule

// File: rtl/bipolar_gain_ctrl.sv
module bipolar_gain_ctrl
    import bgc_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int ROWS   = 8,
    parameter int DATA_W = 16,
    parameter int FRAC   = 8,
    parameter int Q_W    = 16,
    parameter int DT_SH  = 2,
    parameter int TAU_SH = 1,
    parameter int G0     = 16,
    parameter int LAMBDA = 256,
    parameter int LAM_W  = 16,
    parameter int G_MAX  = 192,
    localparam int NPIX  = COLS * ROWS,
    localparam int PIX_W = $clog2(NPIX),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     i_valid,
    input  logic signed [DATA_W-1:0] i_cur,
    output logic                     o_valid,
    output logic signed [DATA_W-1:0] o_v
);

    logic             acc;
    logic [PIX_W-1:0] pix;
    logic [COL_W-1:0] col;
    logic             bank;
    logic             clr_en;
    logic [PIX_W-1:0] clr_addr;
    bgc_state_e       state;
    logic [Q_W-1:0]   g_cur;
    logic [Q_W-1:0]   q_mid;
    logic [PIX_W-1:0] out_pix;

    // Bank and old filtered value travel alongside the Euler pipeline
    logic             s1_bank, s2_bank;
    logic [Q_W-1:0]   s1_q, s2_q;

    bgc_sequencer #(.COLS(COLS), .ROWS(ROWS)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (i_valid),
        .acc      (acc),
        .pix      (pix),
        .col      (col),
        .bank     (bank),
        .clr_en   (clr_en),
        .clr_addr (clr_addr),
        .state    (state)
    );

    bgc_leak #(
        .COLS(COLS), .ROWS(ROWS), .DATA_W(DATA_W), .FRAC(FRAC), .Q_W(Q_W),
        .TAU_SH(TAU_SH), .G0(G0), .LAMBDA(LAMBDA), .LAM_W(LAM_W), .G_MAX(G_MAX)
    ) leak_i (
        .clk      (clk),
        .clr_en   (clr_en),
        .clr_addr (clr_addr),
        .rd_pix   (pix),
        .rd_col   (col),
        .rd_bank  (bank),
        .g_out    (g_cur),
        .q_mid    (q_mid),
        .wr_en    (o_valid),
        .wr_pix   (out_pix),
        .wr_bank  (~s2_bank),
        .wr_v     (o_v),
        .wr_qold  (s2_q)
    );

    bgc_euler #(
        .COLS(COLS), .ROWS(ROWS), .DATA_W(DATA_W), .FRAC(FRAC), .Q_W(Q_W),
        .DT_SH(DT_SH)
    ) euler_i (
        .clk       (clk),
        .rst       (rst),
        .clr_en    (clr_en),
        .clr_addr  (clr_addr),
        .acc       (acc),
        .pix       (pix),
        .cur       (i_cur),
        .g_in      (g_cur),
        .out_valid (o_valid),
        .out_v     (o_v),
        .out_pix   (out_pix)
    );

    always_ff @(posedge clk) begin
        if (acc) begin
            s1_bank <= bank;
            s1_q    <= q_mid;
        end
        s2_bank <= s1_bank;
        s2_q    <= s1_q;
    end

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker
    import bgc_pkg::*;
#(
    parameter int PIX_W = 6,
    parameter int Q_W   = 16,
    parameter int NPIX  = 64,
    parameter int G_MAX = 192
) (
    input logic             clk,
    input logic             rst,
    input logic             acc,
    input logic [PIX_W-1:0] pix,
    input logic             bank,
    input bgc_state_e       state,
    input logic [Q_W-1:0]   g_cur,
    input logic             o_valid
);

    // R2
    lat_out_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> $past(acc, 2));

    // R2
    lat_in_chk: assert property (@(posedge clk) disable iff (rst)
        $past(acc, 2) |-> o_valid);

    // R1
    clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR && $past(state == ST_CLEAR)) |-> !o_valid);

    // R1
    clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |=> $stable(pix));

    // R3
    pix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && pix != PIX_W'(NPIX - 1)) |=> (pix == $past(pix) + PIX_W'(1)));

    // R3
    pix_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && pix == PIX_W'(NPIX - 1)) |=> (pix == '0));

    // R3
    pix_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(pix));

    // R9
    bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank) |-> $past(acc && pix == PIX_W'(NPIX - 1)));

    // R5
    g_cap_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> (g_cur <= Q_W'(G_MAX)));

endmodule

bind bipolar_gain_ctrl bgc_checker #(
    .PIX_W(PIX_W), .Q_W(Q_W), .NPIX(NPIX), .G_MAX(G_MAX)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .pix     (pix),
    .bank    (bank),
    .state   (state),
    .g_cur   (g_cur),
    .o_valid (o_valid)
);

// File: tb/bipolar_gain_ctrl_tb_top.sv
module bipolar_gain_ctrl_tb_top;

    localparam int COLS   = 8;
    localparam int ROWS   = 8;
    localparam int NPIX   = COLS * ROWS;
    localparam int DATA_W = 16;
    localparam int FRAC   = 8;
    localparam int Q_W    = 16;
    localparam int DT_SH  = 2;
    localparam int TAU_SH = 1;
    localparam int G0     = 16;
    localparam int LAMBDA = 256;
    localparam int G_MAX  = 192;
    localparam longint VMAX = 32767;
    localparam longint VMIN = -32768;
    localparam longint QMAX = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_valid = 1'b0;
    logic signed [DATA_W-1:0] i_cur = '0;
    logic o_valid;
    logic signed [DATA_W-1:0] o_v;

    always #10 clk = ~clk;

    bipolar_gain_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .DATA_W(DATA_W), .FRAC(FRAC), .Q_W(Q_W),
        .DT_SH(DT_SH), .TAU_SH(TAU_SH), .G0(G0), .LAMBDA(LAMBDA),
        .LAM_W(16), .G_MAX(G_MAX)
    ) dut_i (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_cur(i_cur),
        .o_valid(o_valid), .o_v(o_v)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    longint exp_q[$];
    string  tag_q[$];

    // Independent model state
    longint mv [NPIX];
    longint mq [2][NPIX];
    int     mbank = 0;
    int     mpix = 0;

    task automatic model_reset();
        for (int p = 0; p < NPIX; p++) begin
            mv[p] = 0;
            mq[0][p] = 0;
            mq[1][p] = 0;
        end
        mbank = 0;
        mpix = 0;
    endtask

    function automatic longint model_step(input longint cur);
        int c;
        longint qa, qb, qc, g, v, leak, d, vn, vsq, q, qn;
        c  = mpix % COLS;
        qb = mq[mbank][mpix];
        qa = (c == 0) ? qb : mq[mbank][mpix-1];
        qc = (c == COLS-1) ? qb : mq[mbank][mpix+1];
        g  = (qa + 2*qb + qc) >>> 2;
        if (g > G_MAX) g = G_MAX;
        v    = mv[mpix];
        leak = (g * v) >>> FRAC;
        d    = cur - leak;
        vn   = v + (d >>> DT_SH);
        if (vn > VMAX) vn = VMAX;
        if (vn < VMIN) vn = VMIN;
        vsq = (vn * vn) >>> FRAC;
        q   = G0 + ((vsq * LAMBDA) >>> FRAC);
        if (q > QMAX) q = QMAX;
        qn = qb + ((q - qb) >>> TAU_SH);
        mq[1-mbank][mpix] = qn;
        mv[mpix] = vn;
        mpix = mpix + 1;
        if (mpix == NPIX) begin
            mpix = 0;
            mbank = 1 - mbank;
        end
        return vn;
    endfunction

    // Driver: present one pixel for one cycle, queue its expected voltage
    task automatic send(input longint cur, input string tag);
        exp_q.push_back(model_step(cur));
        tag_q.push_back(tag);
        i_valid = 1'b1;
        i_cur   = DATA_W'(cur);
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        i_valid = 1'b0;
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_low(input string tag);
        n_chk++;
        if (o_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: o_valid=%b expected 0", tag, o_valid);
        end
    endtask

    // Monitor: compare each produced voltage with the queue head
    always @(negedge clk) begin
        if (!rst && o_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected output o_v=%0d expected none", o_v);
            end else begin
                longint e;
                string  t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (longint'(o_v) != e) begin
                    n_fail++;
                    $display("FAIL %s: o_v=%0d expected %0d", t, o_v, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected under 200000", cycles);
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk_low("R1");
        rst = 1'b0;
        // R1: junk during the clear window is ignored
        for (int k = 0; k < NPIX; k++) begin
            i_valid = 1'b1;
            i_cur   = DATA_W'(12345 + k);
            chk_low("R1");
            @(negedge clk);
        end
        idle(2);
        // R4: first frame, zero state, pure integration
        for (int p = 0; p < NPIX; p++) send(p * 300 - 9000, "R4");
        // R5: column pattern exercises the blur at row edges
        for (int p = 0; p < NPIX; p++)
            send(((p % 2) == 0 ? 1 : -1) * (p % COLS) * 2000, "R5");
        // R7: constant drive, filter settles over frames
        for (int f = 0; f < 3; f++)
            for (int p = 0; p < NPIX; p++) send(4000, "R7");
        // R9: a different drive after a frame boundary
        for (int p = 0; p < NPIX; p++) send((p < NPIX/2) ? 8000 : -6000, "R9");
        // R6: full-scale drive saturates the quadratic term
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < NPIX; p++) send(32767, "R6");
        // R8: voltage climbs into positive then negative saturation
        for (int f = 0; f < 12; f++)
            for (int p = 0; p < NPIX; p++) send(32767, "R8");
        for (int f = 0; f < 14; f++)
            for (int p = 0; p < NPIX; p++) send(-32768, "R8");
        // R3: frames broken by idle gaps
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < NPIX; p++) begin
                send((p * 517) % 9000 - 3000, "R3");
                if ((p % 3) == 2) idle(1);
                if (p == NPIX/2) idle(2);
            end
        idle(6);
        // R2: every accepted pixel produced exactly one output
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending=%0d expected 0", exp_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule